// File: doc/BRIEF.md
# Configurable Two-Input Logic Cell

This block is one programmable logic cell. A 2-input look-up table computes any Boolean function of two operands, A and B. Its result is either presented directly or taken from a flip-flop that captures it on each rising clock edge. A configuration word selects the operand sources, the truth table and the output mode. Operand A comes from one of four feedback candidates or from a software-supplied data bit. Operand B comes from the cell's input pin or from one of four other feedback candidates.

The cell has no streaming data path. All pins are plain levels, and the configuration word is used as presented on every cycle. When the configuration word is all zeros, the cell runs in registered mode with a constant-zero table, so its output settles at 0. Several cells can be chained by wiring one cell's result into another cell's feedback inputs.

Top module: `lut2_cell`

## Requirements
- R1: Configuration bits [10:9] pick entry `fb_mux0[bits 10:9]`. When bit 6 is 1, that entry is operand A.
- R2: When configuration bit 6 is 0, operand A is `sw_bit`.
- R3: Configuration bits [8:7] pick entry `fb_mux1[bits 8:7]`. When bit 5 is 0, that entry is operand B.
- R4: When configuration bit 5 is 1, operand B is `pin_in`.
- R5: Configuration bits [4:1] form a truth table indexed by {A,B}. Bit 4 gives the output for A=1,B=1; bit 3 for A=1,B=0; bit 2 for A=0,B=1; bit 1 for A=0,B=0. For example, 0000 is constant 0, 1111 is constant 1, 0110 is XOR, 0001 is NOR, 1000 is AND, 1100 passes A and 1010 passes B (listed as bits [4:1]).
- R6: When configuration bit 0 is 1, `result` equals the table output in the same cycle, with no clock edge needed.
- R7: When configuration bit 0 is 0, `result` shows the table output captured at the previous rising edge of `clk`. Input changes between edges do not reach `result`.
- R8: While `rst` is high, a rising edge clears the output flip-flop to 0. The clear is synchronous, so `result` does not change before that edge.
- R9: Configuration bits at index 11 and above have no effect on `result`.
- R10: With an all-zero configuration word, `result` is 0 after the first clock edge, whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output flip-flop is updated on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | CFG_W (32) | Configuration word; bits [10:0] are used and the rest are ignored |
| pin_in | input | 1 | The cell's external input pin |
| sw_bit | input | 1 | Software-supplied data bit |
| fb_mux0 | input | 4 | Feedback candidates for operand A |
| fb_mux1 | input | 4 | Feedback candidates for operand B |
| result | output | 1 | Cell output |

## Verification
A table of vectors in bypass mode tests operand routing. For each select code, the chosen feedback bit is set against the opposite value on all the other candidates, so a wrong index gives a wrong output. Truth-table codes are tested with different {A,B} pairs, so that every table bit position is read at least once and a reversed bit order would show up. Directed sequences then separate registered mode from bypass mode by changing inputs between edges, test the synchronous clear against a table that outputs 1, and repeat a routing case with every reserved bit set to 1.

// File: rtl/lut2_cfg_pkg.sv
package lut2_cfg_pkg;
  // Number of feedback candidates per operand multiplexer
  localparam int FB_N   = 4;
  localparam int SEL_W  = $clog2(FB_N);
  localparam int CODE_W = 4;
  localparam int USED_W = 11;

  // Field positions that decoding depends on
  localparam int POS_BYP  = 0;
  localparam int POS_CODE = 1;
  localparam int POS_PIN  = 5;
  localparam int POS_M0EN = 6;
  localparam int POS_SEL1 = 7;
  localparam int POS_SEL0 = 9;

  typedef struct packed {
    logic [SEL_W-1:0]  sel0;
    logic [SEL_W-1:0]  sel1;
    logic              a_from_fb;
    logic              b_from_pin;
    logic [CODE_W-1:0] code;
    logic              bypass;
  } cell_cfg_t;

  function automatic cell_cfg_t decode_cfg(input logic [USED_W-1:0] w);
    cell_cfg_t c;
    c.sel0       = w[POS_SEL0 +: SEL_W];
    c.sel1       = w[POS_SEL1 +: SEL_W];
    c.a_from_fb  = w[POS_M0EN];
    c.b_from_pin = w[POS_PIN];
    c.code       = w[POS_CODE +: CODE_W];
    c.bypass     = w[POS_BYP];
    return c;
  endfunction
endpackage

// File: rtl/lut2_operand_sel.sv
module lut2_operand_sel
  import lut2_cfg_pkg::*;
#(
  parameter int N  = FB_N,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  fb0,
  input  logic [N-1:0]  fb1,
  input  logic [SW-1:0] sel0,
  input  logic [SW-1:0] sel1,
  input  logic          a_from_fb,
  input  logic          b_from_pin,
  input  logic          sw_bit,
  input  logic          pin_in,
  output logic          op_a,
  output logic          op_b
);
  logic m0_out;
  logic m1_out;

  // First level: pick one feedback candidate for each operand
  assign m0_out = fb0[sel0];
  assign m1_out = fb1[sel1];

  // Second level: choose between feedback and the external sources
  always_comb begin
    op_a = a_from_fb  ? m0_out : sw_bit;
    op_b = b_from_pin ? pin_in : m1_out;
  end
endmodule

// File: rtl/lut2_table.sv
module lut2_table
  import lut2_cfg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              op_a,
  input  logic              op_b,
  output logic              y
);
  // Entry index is {A,B}: code[3] for A=1,B=1 down to code[0] for A=0,B=0
  always_comb y = code[{op_a, op_b}];
endmodule

// File: rtl/lut2_out_stage.sv
module lut2_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic bypass,
  output logic q_reg,
  output logic y
);
  always_ff @(posedge clk) begin
    if (rst) q_reg <= 1'b0;
    else     q_reg <= d;
  end

  assign y = bypass ? d : q_reg;

  // Synchronous clear of the holding register
  assert_sync_clear_R8: assert property (@(posedge clk) rst |=> (q_reg == 1'b0))
    else $error("register not cleared after reset edge");
endmodule

// File: rtl/lut2_cell.sv
module lut2_cell
  import lut2_cfg_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             pin_in,
  input  logic             sw_bit,
  input  logic [FB_N-1:0]  fb_mux0,
  input  logic [FB_N-1:0]  fb_mux1,
  output logic             result
);
  localparam int RSV_W = CFG_W - USED_W;

  cell_cfg_t cfg;
  logic      op_a;
  logic      op_b;
  logic      lut_y;
  logic      q_reg;

  assign cfg = decode_cfg(cfg_word[USED_W-1:0]);

  generate
    if (RSV_W > 0) begin : g_rsv
      // Reserved bits take no part in the cell function
      logic unused_rsvd;
      assign unused_rsvd = ^cfg_word[CFG_W-1:USED_W];
    end
  endgenerate

  lut2_operand_sel #(.N(FB_N)) u_sel (
    .fb0        (fb_mux0),
    .fb1        (fb_mux1),
    .sel0       (cfg.sel0),
    .sel1       (cfg.sel1),
    .a_from_fb  (cfg.a_from_fb),
    .b_from_pin (cfg.b_from_pin),
    .sw_bit     (sw_bit),
    .pin_in     (pin_in),
    .op_a       (op_a),
    .op_b       (op_b)
  );

  lut2_table u_lut (
    .code (cfg.code),
    .op_a (op_a),
    .op_b (op_b),
    .y    (lut_y)
  );

  lut2_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .d      (lut_y),
    .bypass (cfg.bypass),
    .q_reg  (q_reg),
    .y      (result)
  );

  // End-to-end: pass-A code with software source in bypass shows sw_bit
  assert_sw_route_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[6:0] == 7'b0011001) |-> (result == sw_bit))
    else $error("software bit not routed to output");

  // End-to-end: pass-B code with pin source in bypass shows pin_in
  assert_pin_route_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[5:0] == 6'b110101) |-> (result == pin_in))
    else $error("pin not routed to output");

  assert_const_one_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[4:0] == 5'b11111) |-> result)
    else $error("constant-one table not high");

  assert_const_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[4:0] == 5'b00001) |-> !result)
    else $error("constant-zero table not low");

  // Registered mode shows the table value from the previous edge
  assert_registered_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_word[0] && !$past(rst)) |-> (result == $past(lut_y)))
    else $error("registered output differs from captured table value");
endmodule

// File: tb/tb_lut2_cell.sv
module tb_lut2_cell;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        pin_in = 1'b0;
  logic        sw_bit = 1'b0;
  logic [3:0]  fb_mux0 = '0;
  logic [3:0]  fb_mux1 = '0;
  logic        result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lut2_cell #(.CFG_W(32)) dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_word (cfg_word),
    .pin_in   (pin_in),
    .sw_bit   (sw_bit),
    .fb_mux0  (fb_mux0),
    .fb_mux1  (fb_mux1),
    .result   (result)
  );

  // Entry: {cfg[10:0], sw, pin, fb0[3:0], fb1[3:0], expected}
  // cfg = {sel0(2), sel1(2), a_from_fb, b_from_pin, code(4), bypass}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {2'd2,2'd0,1'b1,1'b1,4'b1100,1'b1, 1'b0,1'b0,4'b0100,4'b0000,1'b1}, // R1 fb0[2]=1
    {2'd2,2'd0,1'b1,1'b1,4'b1100,1'b1, 1'b1,1'b1,4'b1011,4'b1111,1'b0}, // R1 fb0[2]=0
    {2'd1,2'd0,1'b1,1'b1,4'b1100,1'b1, 1'b0,1'b0,4'b0010,4'b0000,1'b1}, // R1 fb0[1]=1
    {2'd0,2'd0,1'b0,1'b1,4'b1100,1'b1, 1'b1,1'b0,4'b0000,4'b0000,1'b1}, // R2 sw=1
    {2'd0,2'd0,1'b0,1'b1,4'b1100,1'b1, 1'b0,1'b1,4'b1111,4'b1111,1'b0}, // R2 sw=0
    {2'd0,2'd3,1'b0,1'b0,4'b1010,1'b1, 1'b0,1'b0,4'b0000,4'b1000,1'b1}, // R3 fb1[3]=1
    {2'd0,2'd3,1'b0,1'b0,4'b1010,1'b1, 1'b1,1'b1,4'b1111,4'b0111,1'b0}, // R3 fb1[3]=0
    {2'd0,2'd0,1'b0,1'b0,4'b1010,1'b1, 1'b0,1'b0,4'b0000,4'b0001,1'b1}, // R3 fb1[0]=1
    {2'd0,2'd0,1'b0,1'b1,4'b1010,1'b1, 1'b0,1'b1,4'b0000,4'b0000,1'b1}, // R4 pin=1
    {2'd0,2'd0,1'b0,1'b1,4'b1010,1'b1, 1'b1,1'b0,4'b1111,4'b1111,1'b0}, // R4 pin=0
    {2'd0,2'd0,1'b0,1'b1,4'b0110,1'b1, 1'b1,1'b1,4'b0000,4'b0000,1'b0}, // R5 xor 11
    {2'd0,2'd0,1'b0,1'b1,4'b0110,1'b1, 1'b1,1'b0,4'b0000,4'b0000,1'b1}, // R5 xor 10
    {2'd0,2'd0,1'b0,1'b1,4'b0001,1'b1, 1'b0,1'b0,4'b0000,4'b0000,1'b1}, // R5 nor 00
    {2'd0,2'd0,1'b0,1'b1,4'b0001,1'b1, 1'b0,1'b1,4'b0000,4'b0000,1'b0}, // R5 nor 01
    {2'd0,2'd0,1'b0,1'b1,4'b1000,1'b1, 1'b1,1'b1,4'b0000,4'b0000,1'b1}, // R5 and 11
    {2'd0,2'd0,1'b0,1'b1,4'b0010,1'b1, 1'b0,1'b1,4'b0000,4'b0000,1'b1}, // R5 code 0010 at 01
    {2'd0,2'd0,1'b0,1'b1,4'b0100,1'b1, 1'b1,1'b0,4'b0000,4'b0000,1'b1}, // R5 code 0100 at 10
    {2'd0,2'd0,1'b0,1'b1,4'b1111,1'b1, 1'b0,1'b0,4'b0000,4'b0000,1'b1}  // R5 constant one
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: result=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic apply(input logic [21:0] v, input logic [20:0] rsv);
    cfg_word = {rsv, v[21:11]};
    sw_bit   = v[10];
    pin_in   = v[9];
    fb_mux0  = v[8:5];
    fb_mux1  = v[4:1];
  endtask

  initial begin
    // Reset with all-zero configuration
    rst = 1'b1;
    @(posedge clk); #5;
    check(result, 1'b0, "R8 reset state");
    @(negedge clk);
    rst = 1'b0;
    // R10: zero configuration stays at 0 with busy inputs
    sw_bit = 1'b1; pin_in = 1'b1; fb_mux0 = 4'hF; fb_mux1 = 4'hF;
    @(posedge clk); #5;
    check(result, 1'b0, "R10 zero config");
    @(posedge clk); #5;
    check(result, 1'b0, "R10 zero config second edge");

    // Table walk in bypass mode
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i], 21'h0);
      #5;
      check(result, VEC[i][0], $sformatf("R1-5 table vector %0d", i));
    end

    // R9: reserved bits all ones do not change routing
    @(negedge clk);
    apply(VEC[0], 21'h1FFFFF); #5;
    check(result, 1'b1, "R9 reserved ones, fb0 route high");
    @(negedge clk);
    apply(VEC[4], 21'h1FFFFF); #5;
    check(result, 1'b0, "R9 reserved ones, sw route low");

    // R6: bypass follows within the cycle
    @(negedge clk);
    cfg_word = 32'h0000_0019; sw_bit = 1'b0; #3;
    check(result, 1'b0, "R6 bypass low");
    sw_bit = 1'b1; #3;
    check(result, 1'b1, "R6 bypass follows same cycle");

    // R7: registered mode, pass A from sw_bit (cfg 0x18)
    @(negedge clk);
    sw_bit = 1'b0; cfg_word = 32'h0000_0018;
    @(posedge clk); #5;
    check(result, 1'b0, "R7 captured 0");
    @(negedge clk);
    sw_bit = 1'b1; #5;
    check(result, 1'b0, "R7 holds before edge");
    @(posedge clk); #5;
    check(result, 1'b1, "R7 updates after edge");
    @(negedge clk);
    sw_bit = 1'b0; #5;
    check(result, 1'b1, "R7 holds 1 before edge");
    @(posedge clk); #5;
    check(result, 1'b0, "R7 captures 0");

    // R8: synchronous clear while the table outputs 1
    @(negedge clk);
    sw_bit = 1'b1;
    @(posedge clk); #5;
    check(result, 1'b1, "R8 set before reset");
    @(negedge clk);
    rst = 1'b1; #5;
    check(result, 1'b1, "R8 no clear before edge");
    @(posedge clk); #5;
    check(result, 1'b0, "R8 cleared at edge");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    check(result, 1'b1, "R8 resumes after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: result=%b expected=finished", result);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule